// File: doc/BRIEF.md
# LPC bus transaction monitor

A passive observer for a Low-Pin-Count bus. It never drives the 4-bit address/data lines. On every rising edge of the bus clock it samples the frame strobe (active low) and the four address/data lines. From these samples it rebuilds each bus cycle one nibble at a time. The number and order of the nibble phases depend on the cycle type. Read cycles run start, type, address, turn-around, SYNC, data and turn-around. Write cycles move the data nibbles ahead of the first turn-around.

When a cycle completes, is aborted or is rejected, the monitor presents one report for a single clock. The report carries the start code, the cycle type, the address, the data byte, the final SYNC code, the number of SYNC wait clocks and a vector of protocol-violation flags. A debug or trace unit can capture these reports without knowing the bus timing. The synchronous active-low reset doubles as the bus reset and returns the monitor to idle.

Top module: `lpc_txn_monitor`

## Requirements
- R1: While `rst_n` is low at a clock edge, the monitor returns to idle and `rpt_valid` is 0 after that edge. A cycle that was under way when reset arrived produces no report.
- R2: A cycle begins when `frame_n` is sampled low while idle. The start code is the last `lad` value sampled while `frame_n` stays low. If `lad` changes between two such low samples, flag bit 0 (start jitter) is set.
- R3: A start code other than 0000 ends the cycle at the first clock with `frame_n` high. That edge issues a report carrying the start code, flags as gathered, and no further phases.
- R4: With start code 0000, the nibble sampled at the first `frame_n`-high clock is the type. `rpt_ctype` is its bits 3:1: 0 I/O read, 1 I/O write, 2 memory read, 3 memory write, 4 DMA read, 5 DMA write. Type 6 or 7 sets flag bit 1 and reports at once. A set bit 0 of the type nibble sets flag bit 6, and decoding continues.
- R5: The address phase has 4 nibbles for I/O cycles, filling `rpt_addr[15:0]` with the upper bits 0. It has 8 nibbles for memory cycles, filling `rpt_addr` fully. DMA cycles have no address nibbles and report address 0. The most significant nibble comes first.
- R6: Odd types (writes) send the two data nibbles straight after the address, then turn-around, SYNC and turn-around. Even types (reads) send turn-around, SYNC, data and turn-around. The data low nibble is sent first.
- R7: Each turn-around phase lasts 2 clocks. Any of those 4 samples that is not 1111 sets flag bit 2.
- R8: SYNC values 0101 and 0110 are wait clocks. They keep the monitor in SYNC and each one adds 1 to `rpt_waits`, which saturates at all-ones. Any other SYNC value ends the SYNC phase and is reported in `rpt_sync`.
- R9: A terminating SYNC of 1010 sets flag bit 4 (error). A terminating SYNC other than 0000, 1001 or 1010 sets flag bit 3 (reserved).
- R10: `frame_n` sampled low in any phase after the type nibble aborts the cycle. The abort is reported with flag bit 5 set, and that clock's `lad` is taken as the first sample of a new start capture.
- R11: `rpt_valid` is high for exactly the one clock after the edge that samples the last nibble of the second turn-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lclk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Synchronous active-low reset, also bus reset |
| frame_n | input | 1 | Frame strobe, active low |
| lad | input | 4 | Address/data nibble lines |
| rpt_valid | output | 1 | One-clock report strobe |
| rpt_start | output | 4 | Start code of the reported cycle |
| rpt_ctype | output | 3 | Type nibble bits 3:1 |
| rpt_addr | output | ADDR_W (32) | Assembled address |
| rpt_data | output | 8 | Assembled data byte |
| rpt_sync | output | 4 | Terminating SYNC code |
| rpt_waits | output | WAIT_W (8) | SYNC wait clocks, saturating |
| rpt_flags | output | 7 | Violation flags, bit positions per R2 to R10 |

## Verification
The assertions assume that `frame_n` is high throughout reset and that a report flagged as aborted follows a low frame sample. They also assume that the bus does not drive the frame strobe low during the clock in which a non-target start resolves. The stimulus drives `frame_n` only through a nibble task that holds it high during reset and between cycles. Every transaction is built from a complete, legal phase sequence, except where a test breaks one rule on purpose: start jitter, a bad turn-around value, a reserved or error SYNC, an invalid type, an abort or a reset mid-cycle.

// File: rtl/lpc_mon_pkg.sv
// Package: shared codes, flag positions and phase type for the LPC monitor.
// Assumes a 4-bit address/data bus; all values here are protocol constants.
package lpc_mon_pkg;

    localparam int FLAG_W = 7;

    // Flag bit positions in the report vector
    localparam int F_JITTER  = 0;
    localparam int F_BADTYPE = 1;
    localparam int F_TAR     = 2;
    localparam int F_SYNCRSV = 3;
    localparam int F_SYNCERR = 4;
    localparam int F_ABORT   = 5;
    localparam int F_CTLSB   = 6;

    localparam logic [3:0] START_TARGET = 4'h0;
    localparam logic [3:0] TAR_IDLE     = 4'hF;
    localparam logic [3:0] SY_READY     = 4'h0;
    localparam logic [3:0] SY_SHORT     = 4'h5;
    localparam logic [3:0] SY_LONG      = 4'h6;
    localparam logic [3:0] SY_MORE      = 4'h9;
    localparam logic [3:0] SY_ERROR     = 4'hA;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_ADDR,
        PH_DATA,
        PH_TAR1,
        PH_SYNC,
        PH_TAR2
    } phase_e;

endpackage

// File: rtl/lpc_sat_count.sv
// Saturating up-counter for SYNC wait clocks.
// Assumes clr has priority over inc; holds at all-ones.
module lpc_sat_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    // Count up on inc, stop at TOP, clear on clr or reset
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= '0;
        end else if (inc && q != TOP) begin
            q <= q + 1'b1;
        end
    end
endmodule

// File: rtl/lpc_ct_decode.sv
// Decodes the cycle-type nibble into direction, legality and address length.
// Assumes nib[3:2] selects I/O, memory, DMA or illegal; nib[1] is write.
module lpc_ct_decode #(
    parameter int IO_NIB  = 4,
    parameter int MEM_NIB = 8,
    parameter int CNT_W   = 4
) (
    input  logic [3:0]       nib,
    output logic             is_write,
    output logic             bad,
    output logic             lsb_set,
    output logic [CNT_W-1:0] addr_nib
);
    // Pure decode of the type nibble
    always_comb begin
        is_write = nib[1];
        bad      = nib[3] & nib[2];
        lsb_set  = nib[0];
        case (nib[3:2])
            2'b00:   addr_nib = CNT_W'(IO_NIB);
            2'b01:   addr_nib = CNT_W'(MEM_NIB);
            default: addr_nib = '0;
        endcase
    end
endmodule

// File: rtl/lpc_sync_class.sv
// Classifies a SYNC nibble as wait, error or reserved.
// Assumes ready and ready-more are the only other legal terminators.
module lpc_sync_class
    import lpc_mon_pkg::*;
(
    input  logic [3:0] nib,
    output logic       is_wait,
    output logic       is_err,
    output logic       is_rsvd
);
    // Pure decode of the SYNC nibble
    always_comb begin
        is_wait = (nib == SY_SHORT) || (nib == SY_LONG);
        is_err  = (nib == SY_ERROR);
        is_rsvd = !((nib == SY_READY) || (nib == SY_SHORT) || (nib == SY_LONG) ||
                    (nib == SY_MORE)  || (nib == SY_ERROR));
    end
endmodule

// File: rtl/lpc_txn_monitor.sv
// Passive LPC cycle monitor: follows each cycle phase by phase and issues a
// one-clock report per completed, aborted or rejected cycle.
// Assumes frame_n and lad are synchronous to lclk; never drives the bus.
module lpc_txn_monitor
    import lpc_mon_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int IO_ADDR_W = 16,
    parameter int WAIT_W    = 8
) (
    input  logic              lclk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic [3:0]        lad,
    output logic              rpt_valid,
    output logic [3:0]        rpt_start,
    output logic [2:0]        rpt_ctype,
    output logic [ADDR_W-1:0] rpt_addr,
    output logic [7:0]        rpt_data,
    output logic [3:0]        rpt_sync,
    output logic [WAIT_W-1:0] rpt_waits,
    output logic [FLAG_W-1:0] rpt_flags
);
    localparam int MEM_NIB = ADDR_W / 4;
    localparam int IO_NIB  = IO_ADDR_W / 4;
    localparam int CNT_W   = $clog2(MEM_NIB + 1);

    phase_e            phase;
    logic [CNT_W-1:0]  cnt;
    logic              wr_q;
    logic [3:0]        start_q;
    logic [2:0]        ctype_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic [3:0]        sync_q;
    logic [FLAG_W-1:0] flags_q;

    logic              ct_write, ct_bad, ct_lsb;
    logic [CNT_W-1:0]  ct_nib;
    logic              sy_wait, sy_err, sy_rsvd;
    logic              tar_bad;
    logic              in_body;
    logic              wait_clr, wait_inc;
    logic [WAIT_W-1:0] wait_cnt;

    lpc_ct_decode #(
        .IO_NIB  (IO_NIB),
        .MEM_NIB (MEM_NIB),
        .CNT_W   (CNT_W)
    ) u_ct (
        .nib      (lad),
        .is_write (ct_write),
        .bad      (ct_bad),
        .lsb_set  (ct_lsb),
        .addr_nib (ct_nib)
    );

    lpc_sync_class u_sync (
        .nib     (lad),
        .is_wait (sy_wait),
        .is_err  (sy_err),
        .is_rsvd (sy_rsvd)
    );

    // Phase qualifiers feeding the wait counter and abort detection
    always_comb begin
        tar_bad  = (lad != TAR_IDLE);
        in_body  = (phase != PH_IDLE) && (phase != PH_START);
        wait_clr = (phase == PH_START) && frame_n;
        wait_inc = (phase == PH_SYNC) && frame_n && sy_wait;
    end

    lpc_sat_count #(.W(WAIT_W)) u_wait (
        .clk   (lclk),
        .rst_n (rst_n),
        .clr   (wait_clr),
        .inc   (wait_inc),
        .q     (wait_cnt)
    );

    // Phase sequencer, field capture and report generation
    always_ff @(posedge lclk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            wr_q      <= 1'b0;
            start_q   <= '0;
            ctype_q   <= '0;
            addr_q    <= '0;
            data_q    <= '0;
            sync_q    <= '0;
            flags_q   <= '0;
            rpt_valid <= 1'b0;
            rpt_start <= '0;
            rpt_ctype <= '0;
            rpt_addr  <= '0;
            rpt_data  <= '0;
            rpt_sync  <= '0;
            rpt_waits <= '0;
            rpt_flags <= '0;
        end else begin
            rpt_valid <= 1'b0;
            if (in_body && !frame_n) begin
                // Abort: report what was gathered, restart start capture
                rpt_valid <= 1'b1;
                rpt_start <= start_q;
                rpt_ctype <= ctype_q;
                rpt_addr  <= addr_q;
                rpt_data  <= data_q;
                rpt_sync  <= sync_q;
                rpt_waits <= wait_cnt;
                rpt_flags <= flags_q | FLAG_W'(1 << F_ABORT);
                start_q   <= lad;
                flags_q   <= '0;
                cnt       <= '0;
                phase     <= PH_START;
            end else begin
                case (phase)
                    PH_IDLE: begin
                        if (!frame_n) begin
                            start_q <= lad;
                            flags_q <= '0;
                            phase   <= PH_START;
                        end
                    end
                    PH_START: begin
                        if (!frame_n) begin
                            if (lad != start_q) flags_q[F_JITTER] <= 1'b1;
                            start_q <= lad;
                        end else if (start_q != START_TARGET) begin
                            rpt_valid <= 1'b1;
                            rpt_start <= start_q;
                            rpt_ctype <= '0;
                            rpt_addr  <= '0;
                            rpt_data  <= '0;
                            rpt_sync  <= '0;
                            rpt_waits <= '0;
                            rpt_flags <= flags_q;
                            phase     <= PH_IDLE;
                        end else begin
                            ctype_q <= lad[3:1];
                            addr_q  <= '0;
                            data_q  <= '0;
                            sync_q  <= '0;
                            wr_q    <= ct_write;
                            cnt     <= '0;
                            if (ct_bad) begin
                                rpt_valid <= 1'b1;
                                rpt_start <= start_q;
                                rpt_ctype <= lad[3:1];
                                rpt_addr  <= '0;
                                rpt_data  <= '0;
                                rpt_sync  <= '0;
                                rpt_waits <= '0;
                                rpt_flags <= flags_q | FLAG_W'(1 << F_BADTYPE) |
                                             (ct_lsb ? FLAG_W'(1 << F_CTLSB) : '0);
                                phase     <= PH_IDLE;
                            end else begin
                                if (ct_lsb) flags_q[F_CTLSB] <= 1'b1;
                                if (ct_nib != '0) begin
                                    cnt   <= ct_nib - CNT_W'(1);
                                    phase <= PH_ADDR;
                                end else begin
                                    phase <= ct_write ? PH_DATA : PH_TAR1;
                                end
                            end
                        end
                    end
                    PH_ADDR: begin
                        addr_q <= {addr_q[ADDR_W-5:0], lad};
                        if (cnt == '0) begin
                            phase <= wr_q ? PH_DATA : PH_TAR1;
                        end else begin
                            cnt <= cnt - CNT_W'(1);
                        end
                    end
                    PH_DATA: begin
                        if (cnt == '0) begin
                            data_q[3:0] <= lad;
                            cnt         <= CNT_W'(1);
                        end else begin
                            data_q[7:4] <= lad;
                            cnt         <= '0;
                            phase       <= wr_q ? PH_TAR1 : PH_TAR2;
                        end
                    end
                    PH_TAR1: begin
                        if (tar_bad) flags_q[F_TAR] <= 1'b1;
                        if (cnt == '0) begin
                            cnt <= CNT_W'(1);
                        end else begin
                            cnt   <= '0;
                            phase <= PH_SYNC;
                        end
                    end
                    PH_SYNC: begin
                        if (!sy_wait) begin
                            sync_q <= lad;
                            if (sy_err)  flags_q[F_SYNCERR] <= 1'b1;
                            if (sy_rsvd) flags_q[F_SYNCRSV] <= 1'b1;
                            cnt   <= '0;
                            phase <= wr_q ? PH_TAR2 : PH_DATA;
                        end
                    end
                    PH_TAR2: begin
                        if (cnt == '0) begin
                            if (tar_bad) flags_q[F_TAR] <= 1'b1;
                            cnt <= CNT_W'(1);
                        end else begin
                            rpt_valid <= 1'b1;
                            rpt_start <= start_q;
                            rpt_ctype <= ctype_q;
                            rpt_addr  <= addr_q;
                            rpt_data  <= data_q;
                            rpt_sync  <= sync_q;
                            rpt_waits <= wait_cnt;
                            rpt_flags <= flags_q | (tar_bad ? FLAG_W'(1 << F_TAR) : '0);
                            cnt       <= '0;
                            phase     <= PH_IDLE;
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/lpc_txn_monitor_sva.sv
// Checker for the LPC monitor's report port, bound to every instance.
// Assumes frame_n is high during reset.
module lpc_txn_monitor_sva
    import lpc_mon_pkg::*;
(
    input logic              lclk,
    input logic              rst_n,
    input logic              frame_n,
    input logic              rpt_valid,
    input logic [3:0]        rpt_start,
    input logic [2:0]        rpt_ctype,
    input logic [3:0]        rpt_sync,
    input logic [FLAG_W-1:0] rpt_flags
);
    a_r1_reset_quiet: assert property (@(posedge lclk)
        !rst_n |=> !rpt_valid);

    a_r4_bad_type_code: assert property (@(posedge lclk) disable iff (!rst_n)
        (rpt_valid && rpt_flags[F_BADTYPE]) |-> (rpt_ctype[2:1] == 2'b11));

    a_r9_error_code: assert property (@(posedge lclk) disable iff (!rst_n)
        (rpt_valid && rpt_flags[F_SYNCERR]) |-> (rpt_sync == SY_ERROR));

    a_r9_reserved_code: assert property (@(posedge lclk) disable iff (!rst_n)
        (rpt_valid && rpt_flags[F_SYNCRSV]) |->
        !(rpt_sync == SY_READY || rpt_sync == SY_MORE || rpt_sync == SY_ERROR ||
          rpt_sync == SY_SHORT || rpt_sync == SY_LONG));

    a_r10_abort_cause: assert property (@(posedge lclk) disable iff (!rst_n)
        (rpt_valid && rpt_flags[F_ABORT]) |-> $past(!frame_n));

    a_r3_start_report_frame_high: assert property (@(posedge lclk) disable iff (!rst_n)
        (rpt_valid && (rpt_start != START_TARGET) && !rpt_flags[F_ABORT]) |-> $past(frame_n));

    a_r11_done_frame_high: assert property (@(posedge lclk) disable iff (!rst_n)
        (rpt_valid && !rpt_flags[F_ABORT]) |-> $past(frame_n));
endmodule

bind lpc_txn_monitor lpc_txn_monitor_sva u_sva (
    .lclk      (lclk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .rpt_valid (rpt_valid),
    .rpt_start (rpt_start),
    .rpt_ctype (rpt_ctype),
    .rpt_sync  (rpt_sync),
    .rpt_flags (rpt_flags)
);

// File: tb/tb_lpc_txn_monitor.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected reports, a monitor compares.
module tb_lpc_txn_monitor;
    logic        lclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic [3:0]  lad = 4'hF;
    logic        rpt_valid;
    logic [3:0]  rpt_start;
    logic [2:0]  rpt_ctype;
    logic [31:0] rpt_addr;
    logic [7:0]  rpt_data;
    logic [3:0]  rpt_sync;
    logic [7:0]  rpt_waits;
    logic [6:0]  rpt_flags;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    typedef struct packed {
        logic [1:0]  mode;   // 0 start+flags, 1 +ctype, 2 all fields
        logic [3:0]  start;
        logic [2:0]  ctype;
        logic [31:0] addr;
        logic [7:0]  data;
        logic [3:0]  sync;
        logic [7:0]  waits;
        logic [6:0]  flags;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #10 lclk = ~lclk;

    lpc_txn_monitor dut (
        .lclk(lclk), .rst_n(rst_n), .frame_n(frame_n), .lad(lad),
        .rpt_valid(rpt_valid), .rpt_start(rpt_start), .rpt_ctype(rpt_ctype),
        .rpt_addr(rpt_addr), .rpt_data(rpt_data), .rpt_sync(rpt_sync),
        .rpt_waits(rpt_waits), .rpt_flags(rpt_flags)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic clk1(input logic f, input logic [3:0] v);
        @(negedge lclk);
        frame_n = f;
        lad     = v;
    endtask

    task automatic push(input logic [1:0] m, input logic [3:0] st, input logic [2:0] ct,
                        input logic [31:0] a, input logic [7:0] d, input logic [3:0] sy,
                        input logic [7:0] w, input logic [6:0] fl, input string tag);
        exp_t e;
        e = '{mode: m, start: st, ctype: ct, addr: a, data: d, sync: sy, waits: w, flags: fl};
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Drives a target cycle: start 0000, type, address, data/TAR/SYNC by direction
    task automatic lpc_cycle(input logic [3:0] ct, input logic [31:0] a, input int nnib,
                             input bit wr, input logic [7:0] d, input int nwait,
                             input logic [3:0] term, input logic [3:0] t1, input logic [3:0] t2);
        clk1(1'b0, 4'h0);
        clk1(1'b1, ct);
        for (int i = nnib - 1; i >= 0; i--) clk1(1'b1, a[i*4 +: 4]);
        if (wr) begin clk1(1'b1, d[3:0]); clk1(1'b1, d[7:4]); end
        clk1(1'b1, 4'hF);
        clk1(1'b1, t1);
        for (int k = 0; k < nwait; k++) clk1(1'b1, (k % 2) ? 4'h6 : 4'h5);
        clk1(1'b1, term);
        if (!wr) begin clk1(1'b1, d[3:0]); clk1(1'b1, d[7:4]); end
        clk1(1'b1, 4'hF);
        clk1(1'b1, t2);
        clk1(1'b1, 4'hF);
    endtask

    // Scoreboard monitor: compare each report against the queue head
    initial begin
        forever begin
            @(negedge lclk);
            if (rst_n && rpt_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected report", {rpt_start, rpt_flags}, 0);
                end else begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(rpt_start == e.start, {t, " start"}, rpt_start, e.start);
                    chk(rpt_flags == e.flags, {t, " flags"}, rpt_flags, e.flags);
                    if (e.mode >= 2'd1)
                        chk(rpt_ctype == e.ctype, {t, " ctype"}, rpt_ctype, e.ctype);
                    if (e.mode == 2'd2) begin
                        chk(rpt_addr  == e.addr,  {t, " addr"},  rpt_addr,  e.addr);
                        chk(rpt_data  == e.data,  {t, " data"},  rpt_data,  e.data);
                        chk(rpt_sync  == e.sync,  {t, " sync"},  rpt_sync,  e.sync);
                        chk(rpt_waits == e.waits, {t, " waits"}, rpt_waits, e.waits);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge lclk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R11 watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge lclk);
        chk(rpt_valid == 1'b0, "R1 reset strobe", rpt_valid, 0);
        @(negedge lclk);
        rst_n = 1'b1;
        repeat (2) @(negedge lclk);

        // R5 I/O read, 16-bit address MSN first
        push(2, 4'h0, 3'd0, 32'h0000_1234, 8'h5A, 4'h0, 8'd0, 7'h00, "R5");
        lpc_cycle(4'h0, 32'h1234, 4, 1'b0, 8'h5A, 0, 4'h0, 4'hF, 4'hF);
        chk(rpt_valid == 1'b1, "R11 strobe high", rpt_valid, 1);
        @(negedge lclk);
        chk(rpt_valid == 1'b0, "R11 strobe one clock", rpt_valid, 0);

        // R6 memory write, data before SYNC; R8 three waits
        push(2, 4'h0, 3'd3, 32'hDEAD_BEEF, 8'h3C, 4'h0, 8'd3, 7'h00, "R6");
        lpc_cycle(4'h6, 32'hDEAD_BEEF, 8, 1'b1, 8'h3C, 3, 4'h0, 4'hF, 4'hF);

        // R7 bad turn-around plus R9 error SYNC on an I/O write
        push(2, 4'h0, 3'd1, 32'h0000_0080, 8'h11, 4'hA, 8'd0, 7'h14, "R7");
        lpc_cycle(4'h2, 32'h0080, 4, 1'b1, 8'h11, 0, 4'hA, 4'hE, 4'hF);

        // R9 reserved SYNC on a memory read
        push(2, 4'h0, 3'd2, 32'h0000_0010, 8'h99, 4'h3, 8'd0, 7'h08, "R9");
        lpc_cycle(4'h4, 32'h10, 8, 1'b0, 8'h99, 0, 4'h3, 4'hF, 4'hF);

        // R2 multi-clock start with changing LAD
        push(2, 4'h0, 3'd0, 32'h0000_0001, 8'h00, 4'h0, 8'd0, 7'h01, "R2");
        clk1(1'b0, 4'h3);
        lpc_cycle(4'h0, 32'h1, 4, 1'b0, 8'h00, 0, 4'h0, 4'hF, 4'hF);

        // R3 non-target start codes: stop/abort and grant
        push(0, 4'hF, 3'd0, 0, 0, 0, 0, 7'h00, "R3");
        clk1(1'b0, 4'hF); clk1(1'b1, 4'h0); clk1(1'b1, 4'hF);
        push(0, 4'h2, 3'd0, 0, 0, 0, 0, 7'h00, "R3");
        clk1(1'b0, 4'h2); clk1(1'b1, 4'hF); clk1(1'b1, 4'hF);

        // R4 illegal type 11xx
        push(1, 4'h0, 3'd6, 0, 0, 0, 0, 7'h02, "R4");
        clk1(1'b0, 4'h0); clk1(1'b1, 4'hC); clk1(1'b1, 4'hF); clk1(1'b1, 4'hF);

        // R4 type bit 0 set, still decoded as memory read
        push(2, 4'h0, 3'd2, 32'hA5A5_A5A5, 8'h42, 4'h0, 8'd0, 7'h40, "R4");
        lpc_cycle(4'h5, 32'hA5A5_A5A5, 8, 1'b0, 8'h42, 0, 4'h0, 4'hF, 4'hF);

        // R5 DMA read and write: no address nibbles
        push(2, 4'h0, 3'd4, 32'h0, 8'h77, 4'h9, 8'd0, 7'h00, "R5");
        lpc_cycle(4'h8, 32'h0, 0, 1'b0, 8'h77, 0, 4'h9, 4'hF, 4'hF);
        push(2, 4'h0, 3'd5, 32'h0, 8'h88, 4'h0, 8'd1, 7'h00, "R6");
        lpc_cycle(4'hA, 32'h0, 0, 1'b1, 8'h88, 1, 4'h0, 4'hF, 4'hF);

        // R10 abort during address, then the restarted cycle completes
        push(0, 4'h0, 3'd0, 0, 0, 0, 0, 7'h20, "R10");
        push(2, 4'h0, 3'd0, 32'h0000_BEEF, 8'hC3, 4'h0, 8'd0, 7'h00, "R10");
        clk1(1'b0, 4'h0); clk1(1'b1, 4'h4); clk1(1'b1, 4'h1); clk1(1'b1, 4'h2);
        lpc_cycle(4'h0, 32'hBEEF, 4, 1'b0, 8'hC3, 0, 4'h0, 4'hF, 4'hF);

        // R8 wait count saturation
        push(2, 4'h0, 3'd3, 32'h0000_0004, 8'h5E, 4'h0, 8'hFF, 7'h00, "R8");
        lpc_cycle(4'h6, 32'h4, 8, 1'b1, 8'h5E, 300, 4'h0, 4'hF, 4'hF);

        // R1 reset mid-cycle: no report, then a clean cycle
        clk1(1'b0, 4'h0); clk1(1'b1, 4'h4); clk1(1'b1, 4'h1); clk1(1'b1, 4'hF);
        @(negedge lclk); rst_n = 1'b0;
        @(negedge lclk); rst_n = 1'b1;
        push(2, 4'h0, 3'd0, 32'h0000_0ABC, 8'h01, 4'h0, 8'd0, 7'h00, "R1");
        lpc_cycle(4'h0, 32'h0ABC, 4, 1'b0, 8'h01, 0, 4'h0, 4'hF, 4'hF);

        repeat (5) @(negedge lclk);
        chk(exp_q.size() == 0, "R11 all reports seen", exp_q.size(), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule